// File: doc/BRIEF.md
# Partial-Width General Register File

This block holds eight 32-bit general registers. Each one can be read or written as a whole doubleword, as its low 16-bit word, or as a single byte. Byte access is limited to the first four registers, and there it reaches either bits 7:0 or bits 15:8. A 3-bit register specifier and a 2-bit size code choose the field for every access.

There are two combinational read ports and one write port that updates on the clock edge. A write merges the new data at the byte level, so bits outside the addressed field keep their value. A partial read returns the chosen field, zero-extended to 32 bits. An instruction decoder that wants mixed-width register access would use it as its architectural register store.

Register indices: 0 accumulator, 1 count, 2 data, 3 base, 4 stack pointer, 5 base pointer, 6 source index, 7 destination index.

Top module: `gpr_partial_file`

## Requirements
- R1: Size code 2'b10 selects a 32-bit access to register `spec`. A write replaces all 32 bits.
- R2: Size code 2'b01 selects a 16-bit access to bits 15:0 of register `spec`. A write changes only bits 15:0. A read returns {16'h0, bits 15:0}.
- R3: Size code 2'b00 with `spec` 0 to 3 selects bits 7:0 of register `spec`. A write changes only those bits. A read returns them zero-extended.
- R4: Size code 2'b00 with `spec` 4 to 7 selects bits 15:8 of register `spec`-4. A write changes only those bits. A read returns them in bits 7:0 with zeros above.
- R5: The block treats size code 2'b11 as 32-bit access.
- R6: If a read port addresses the register being written in the same cycle, it returns the old contents. The new value appears from the next cycle on.
- R7: A synchronous reset clears all eight registers to zero.
- R8: A write changes only the addressed register. It does not change the other seven.
- R9: When the write enable is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_spec | input | 3 | Write register specifier |
| wr_size | input | 2 | Write size code |
| wr_data | input | 32 | Write data; the field value sits in the low bits |
| rd_a_spec | input | 3 | Read port A specifier |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_data | output | 32 | Read port A zero-extended data |
| rd_b_spec | input | 3 | Read port B specifier |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 32 | Read port B zero-extended data |

## Verification
The bench focuses on high-byte accesses through specifiers 4 to 7. A design that decodes these the same way as the 16-bit or 32-bit cases would write to the stack pointer and the index registers instead of bits 15:8 of the first four. It also checks that partial writes keep the rest of the register intact. An implementation that writes the whole register would clear the upper bits or the neighbouring byte. Same-cycle read and write is also covered, where a forwarding path would show the new value one cycle early. Size code 3 is tested to confirm it behaves as a full-width access.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned NREG = 8;
  localparam int unsigned SW = $clog2(NREG);
  localparam int unsigned NLANE = DW / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_ALT = 2'b11
  } size_e;

  typedef struct packed {
    logic [SW-1:0] idx;
    logic [NLANE-1:0] lanes;
    logic hi_byte;
  } target_t;

  function automatic target_t decode(input logic [SW-1:0] spec, input logic [1:0] size);
    target_t t;
    t.idx = spec;
    t.hi_byte = 1'b0;
    t.lanes = '1;
    if (size == SZ_WORD) begin
      t.lanes = NLANE'(4'b0011);
    end else if (size == SZ_BYTE) begin
      t.hi_byte = spec[SW-1];
      t.idx = {1'b0, spec[SW-2:0]};
      t.lanes = spec[SW-1] ? NLANE'(4'b0010) : NLANE'(4'b0001);
    end
    return t;
  endfunction
endpackage

// File: rtl/gpr_spec_decode.sv
module gpr_spec_decode
  import gpr_pkg::*;
(
  input  logic [SW-1:0] spec,
  input  logic [1:0]    size,
  output target_t       tgt
);
  assign tgt = decode(spec, size);
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
(
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [SW-1:0]           spec,
  input  logic [1:0]              size,
  output logic [DW-1:0]           data
);
  target_t tgt;
  logic [DW-1:0] word;

  gpr_spec_decode u_dec (.spec(spec), .size(size), .tgt(tgt));

  assign word = regs[tgt.idx];

  always_comb begin
    data = '0;
    for (int i = 0; i < NLANE; i++) begin
      if (tgt.lanes[i]) data[i*8 +: 8] = word[i*8 +: 8];
    end
    if (tgt.hi_byte) data = {{(DW-8){1'b0}}, word[15:8]};
  end
endmodule

// File: rtl/gpr_partial_file.sv
module gpr_partial_file
  import gpr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2:0]           wr_spec,
  input  logic [1:0]           wr_size,
  input  logic [31:0]          wr_data,
  input  logic [2:0]           rd_a_spec,
  input  logic [1:0]           rd_a_size,
  output logic [31:0]          rd_a_data,
  input  logic [2:0]           rd_b_spec,
  input  logic [1:0]           rd_b_size,
  output logic [31:0]          rd_b_data
);
  logic [NREG-1:0][DW-1:0] regs;
  target_t wtgt;
  logic [DW-1:0] wr_aligned;
  logic [NREG-1:0][NLANE-1:0] lane_we;

  gpr_spec_decode u_wdec (.spec(wr_spec), .size(wr_size), .tgt(wtgt));

  assign wr_aligned = wtgt.hi_byte ? {wr_data[DW-9:0], 8'h00} : wr_data;

  genvar r, l;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      for (l = 0; l < NLANE; l++) begin : g_lane
        assign lane_we[r][l] = wr_en && (wtgt.idx == SW'(r)) && wtgt.lanes[l];
        always_ff @(posedge clk) begin
          if (rst) regs[r][l*8 +: 8] <= 8'h00;
          else if (lane_we[r][l]) regs[r][l*8 +: 8] <= wr_aligned[l*8 +: 8];
        end
      end
    end
  endgenerate

  gpr_read_port u_rda (.regs(regs), .spec(rd_a_spec), .size(rd_a_size), .data(rd_a_data));
  gpr_read_port u_rdb (.regs(regs), .spec(rd_b_spec), .size(rd_b_size), .data(rd_b_data));
endmodule

// File: rtl/gpr_partial_file_chk.sv
module gpr_partial_file_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [2:0]  wr_spec,
  input logic [1:0]  wr_size,
  input logic [2:0]  rd_a_spec,
  input logic [1:0]  rd_a_size,
  input logic [31:0] rd_a_data,
  input logic [7:0][3:0] lane_we
);
  logic [31:0] lane_flat;
  assign lane_flat = lane_we;

  AST_ONE_REG_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    $countones(lane_flat) <= 4) else $error("lane count"); // R8
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> lane_flat == 32'h0) else $error("idle write"); // R9
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b00) |-> $countones(lane_flat) == 1) else $error("byte lanes"); // R3
  AST_HI_BYTE_LANE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b00 && wr_spec[2]) |-> lane_we[wr_spec[1:0]][1]) else $error("hi lane"); // R4
  AST_WORD_LANES: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b01) |-> lane_we[wr_spec] == 4'b0011) else $error("word lanes"); // R2
  AST_READ_ZEXT: assert property (@(posedge clk) disable iff (rst)
    rd_a_size == 2'b00 |-> rd_a_data[31:8] == 24'h0) else $error("zext"); // R3
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr_en) && !wr_en && $stable(rd_a_spec) && $stable(rd_a_size) && !$past(rst))
      |-> $stable(rd_a_data)) else $error("hold"); // R9
endmodule

bind gpr_partial_file gpr_partial_file_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_spec(wr_spec), .wr_size(wr_size),
  .rd_a_spec(rd_a_spec), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
  .lane_we(lane_we)
);

// File: tb/gpr_partial_file_tb.sv
module gpr_partial_file_tb;
  logic clk = 0, rst = 1, wr_en = 0;
  logic [2:0] wr_spec = 0, rd_a_spec = 0, rd_b_spec = 0;
  logic [1:0] wr_size = 0, rd_a_size = 2, rd_b_size = 2;
  logic [31:0] wr_data = 0, rd_a_data, rd_b_data;
  logic [31:0] model [8];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpr_partial_file u_dut (.*);

  function automatic logic [31:0] exp_read(input logic [2:0] s, input logic [1:0] z);
    if (z == 2'b01) return {16'h0, model[s][15:0]};
    if (z == 2'b00) return s >= 4 ? {24'h0, model[s-4][15:8]} : {24'h0, model[s][7:0]};
    return model[s];
  endfunction

  function automatic void model_write(input logic [2:0] s, input logic [1:0] z, input logic [31:0] d);
    if (z == 2'b01) model[s][15:0] = d[15:0];
    else if (z == 2'b00) begin
      if (s >= 4) model[s-4][15:8] = d[7:0];
      else model[s][7:0] = d[7:0];
    end else model[s] = d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] z, input logic [31:0] d);
    wr_en = 1; wr_spec = s; wr_size = z; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    model_write(s, z, d);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_a_spec = 3'(i); rd_a_size = 2'b10; #1;
      chk(req, rd_a_data, model[i]);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) model[i] = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) begin
      wr_en = 1; wr_spec = 3'(i); wr_size = 2; wr_data = 32'hFFFF_FFFF;
      @(posedge clk); #1;
    end
    wr_en = 0;
    rst = 1; @(posedge clk); #1; rst = 0;
    for (int i = 0; i < 8; i++) model[i] = 0;
    check_all("R7");
    // R1 full write
    wr(3, 2'b10, 32'hDEAD_BEEF);
    rd_a_spec = 3; rd_a_size = 2'b10; #1; chk("R1", rd_a_data, 32'hDEAD_BEEF);
    // R2 word write keeps upper
    wr(3, 2'b01, 32'h1234_5678);
    #1; chk("R2", rd_a_data, 32'hDEAD_5678);
    rd_b_spec = 3; rd_b_size = 2'b01; #1; chk("R2", rd_b_data, 32'h0000_5678);
    // R3 low byte
    wr(3, 2'b00, 32'hAAAA_AA11);
    #1; chk("R3", rd_a_data, 32'hDEAD_5611);
    rd_b_size = 2'b00; rd_b_spec = 3; #1; chk("R3", rd_b_data, 32'h11);
    // R4 high byte via spec 7 reaches reg 3 bits 15:8
    wr(7, 2'b00, 32'h0000_00C3);
    #1; chk("R4", rd_a_data, 32'hDEAD_C311);
    rd_b_spec = 7; #1; chk("R4", rd_b_data, 32'hC3);
    rd_a_spec = 7; rd_a_size = 2'b10; #1; chk("R4", rd_a_data, 32'h0);
    // R5 size 3 as full
    wr(5, 2'b11, 32'hCAFE_F00D);
    rd_a_spec = 5; rd_a_size = 2'b11; #1; chk("R5", rd_a_data, 32'hCAFE_F00D);
    // R6 same-cycle read-old
    rd_a_spec = 5; rd_a_size = 2'b10;
    wr_en = 1; wr_spec = 5; wr_size = 2; wr_data = 32'h0BAD_0BAD; #1;
    chk("R6", rd_a_data, 32'hCAFE_F00D);
    @(posedge clk); #1; wr_en = 0; model_write(5, 2, 32'h0BAD_0BAD);
    chk("R6", rd_a_data, 32'h0BAD_0BAD);
    check_all("R8");
    // R9 enable low
    wr_en = 0; wr_spec = 0; wr_size = 2; wr_data = 32'h5555_5555;
    @(posedge clk); #1; check_all("R9");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0] s; logic [1:0] z; logic [31:0] d;
      s = 3'($urandom); z = 2'($urandom); d = $urandom;
      if (($urandom % 4) == 0) begin
        wr_en = 0; wr_spec = s; wr_size = z; wr_data = d;
        @(posedge clk); #1;
      end else wr(s, z, d);
      rd_a_spec = 3'($urandom); rd_a_size = 2'($urandom);
      rd_b_spec = 3'($urandom); rd_b_size = 2'($urandom); #1;
      chk("R8", rd_a_data, exp_read(rd_a_spec, rd_a_size));
      chk("R3", rd_b_data, exp_read(rd_b_spec, rd_b_size));
    end
    check_all("R8");
    rst = 1; @(posedge clk); #1; rst = 0;
    for (int i = 0; i < 8; i++) model[i] = 0;
    check_all("R7");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule